// File: doc/BRIEF.md
# Interrupt source state controller

This block keeps the per-source state of a set of interrupt sources and turns input activity and software commands into interrupt offers for a presentation stage. Each source is either level-triggered or edge/message-triggered, holds a target server, a current priority and a saved priority, and tracks four flags: asserted, sent, rejected and pending-while-masked. A priority value of 0xFF masks a source. Sources are numbered from a base value `SRC_BASE` upward, and all numbers on the ports are in that space.

Commands (configure, disable, enable) arrive on a one-cycle command strobe and are answered one cycle later with an acknowledge and an error flag. The presentation stage returns reject and end-of-interrupt notices for a source number, and a resend pulse that makes every source reconsider its pending state. Offers leave through a single valid/ready register carrying source number, server and priority. When several sources are due, the lowest index is offered first, and nothing new is offered while an offer is waiting.

Top module: `irq_source_ctrl`

## Requirements
- R1: After reset every source is masked (priority and saved priority 0xFF), server 0, all flags clear; `offerValid` and `cmdAck` are low.
- R2: A rising edge on the input of a message source (srcIsLevel bit 0) whose priority is not 0xFF produces one offer {SRC_BASE+i, server, priority}; if the priority is 0xFF the source instead becomes pending-while-masked and offers nothing.
- R3: A level source (srcIsLevel bit 1) follows its input in the asserted flag; on each input change it offers, and marks itself sent, only when unmasked, asserted and not sent. While the input stays high it is not offered again.
- R4: A reject for a source number sets its rejected flag and clears its sent flag; it causes no offer by itself.
- R5: An end-of-interrupt clears the sent flag of a level source; for a message source it changes nothing.
- R6: A resend pulse makes level sources reapply the R3 rule; a message source with rejected set clears it and, if unmasked, re-offers exactly once.
- R7: A configure command (cmdOp 0) sets server, priority and saved priority; a pending-while-masked message source that receives a priority other than 0xFF clears that flag and offers; a level source reapplies the R3 rule.
- R8: Disable (cmdOp 1) moves the current priority into saved priority and sets priority to 0xFF; enable (cmdOp 2) copies saved priority into priority. Both then apply the R7 follow-up rule.
- R9: Every command is acknowledged on `cmdAck` the cycle after `cmdValid`. `cmdErr` is 1 and no state changes when the number is outside SRC_BASE..SRC_BASE+NUM_SRC-1, when a configure names a server not below NUM_SERVERS or a priority above 0xFF (cmdPrio bit 8 set), or when cmdOp is 3.
- R10: At most one offer is launched per cycle; due sources are offered in ascending index order; an offer holds all its fields stable while `offerReady` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| srcIsLevel | input | NUM_SRC | Per-source type, 1 = level, 0 = message |
| srcLine | input | NUM_SRC | Per-source interrupt input |
| cmdValid | input | 1 | Command strobe |
| cmdOp | input | 2 | 0 configure, 1 disable, 2 enable, 3 invalid |
| cmdNum | input | NUM_W | Source number of the command |
| cmdServer | input | SRV_IN_W | Target server for configure |
| cmdPrio | input | 9 | Priority for configure |
| cmdAck | output | 1 | Command answered (one cycle after strobe) |
| cmdErr | output | 1 | Command refused, valid with cmdAck |
| rejValid | input | 1 | Reject notice strobe |
| rejNum | input | NUM_W | Rejected source number |
| eoiValid | input | 1 | End-of-interrupt strobe |
| eoiNum | input | NUM_W | Source number of the end-of-interrupt |
| resendReq | input | 1 | Resend pulse |
| offerValid | output | 1 | Offer present |
| offerReady | input | 1 | Offer taken this cycle |
| offerNum | output | NUM_W | Offered source number |
| offerServer | output | SRV_W | Offered target server |
| offerPrio | output | 8 | Offered priority |

## Verification
The bench targets the flag interplay: a rejected level source that is still asserted must stay silent until a resend, so a design that re-evaluates level sources every cycle would show an extra offer; an end-of-interrupt on a message source followed by resend must stay silent, catching a design that treats both types alike. Masked message edges must be remembered and released by enable or configure, so a design that drops them misses an offer. Refused commands are followed by a trigger whose offer must carry the old server and priority, exposing any partial write, and a stalled multi-source burst exposes wrong ordering or fields that change while held.

// File: rtl/irq_source_ctrl_pkg.sv
package irq_source_ctrl_pkg;

  localparam logic [7:0] MASK_PRIO = 8'hFF;

  typedef enum logic [1:0] {
    OP_CONFIG  = 2'd0,
    OP_DISABLE = 2'd1,
    OP_ENABLE  = 2'd2,
    OP_BAD     = 2'd3
  } cmd_op_e;

  // Strobes from control to the source-state datapath
  typedef struct packed {
    logic cfgWr;
    logic disWr;
    logic enWr;
    logic rejHit;
    logic eoiHit;
    logic resend;
    logic launch;
  } strobe_t;

endpackage

// File: rtl/irq_source_ctrl_ctl.sv
module irq_source_ctrl_ctl
  import irq_source_ctrl_pkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int SRC_BASE    = 16,
  parameter int NUM_SERVERS = 4,
  parameter int NUM_W       = 8,
  parameter int SRV_IN_W    = 8,
  localparam int IDX_W      = $clog2(NUM_SRC),
  localparam int SRV_W      = $clog2(NUM_SERVERS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmdValid,
  input  logic [1:0]          cmdOp,
  input  logic [NUM_W-1:0]    cmdNum,
  input  logic [SRV_IN_W-1:0] cmdServer,
  input  logic [8:0]          cmdPrio,
  input  logic                rejValid,
  input  logic [NUM_W-1:0]    rejNum,
  input  logic                eoiValid,
  input  logic [NUM_W-1:0]    eoiNum,
  input  logic                resendReq,
  input  logic [NUM_SRC-1:0]  dueVec,
  input  logic [SRV_W-1:0]    selServer,
  input  logic [7:0]          selPrio,
  input  logic                offerReady,
  output strobe_t             strb,
  output logic [IDX_W-1:0]    cmdIdx,
  output logic [IDX_W-1:0]    rejIdx,
  output logic [IDX_W-1:0]    eoiIdx,
  output logic [IDX_W-1:0]    launchIdx,
  output logic [SRV_W-1:0]    wrServer,
  output logic [7:0]          wrPrio,
  output logic                cmdAck,
  output logic                cmdErr,
  output logic                offerValid,
  output logic [NUM_W-1:0]    offerNum,
  output logic [SRV_W-1:0]    offerServer,
  output logic [7:0]          offerPrio
);

  function automatic logic inRange(input logic [NUM_W-1:0] n);
    return (int'(n) >= SRC_BASE) && (int'(n) < SRC_BASE + NUM_SRC);
  endfunction

  function automatic logic [IDX_W-1:0] toIdx(input logic [NUM_W-1:0] n);
    return IDX_W'(n - NUM_W'(SRC_BASE));
  endfunction

  logic numOk, cfgOk, cmdOk, anyDue, slotFree;
  logic [IDX_W-1:0] pickIdx;

  assign numOk = inRange(cmdNum);
  assign cfgOk = numOk && (int'(cmdServer) < NUM_SERVERS) && !cmdPrio[8];

  always_comb begin
    unique case (cmd_op_e'(cmdOp))
      OP_CONFIG:  cmdOk = cfgOk;
      OP_DISABLE: cmdOk = numOk;
      OP_ENABLE:  cmdOk = numOk;
      default:    cmdOk = 1'b0;
    endcase
  end

  // Lowest-index due source wins
  always_comb begin
    pickIdx = '0;
    anyDue  = 1'b0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (dueVec[i]) begin
        pickIdx = IDX_W'(i);
        anyDue  = 1'b1;
      end
    end
  end

  assign slotFree = !offerValid || offerReady;

  always_comb begin
    strb.cfgWr  = cmdValid && cmdOk && (cmd_op_e'(cmdOp) == OP_CONFIG);
    strb.disWr  = cmdValid && cmdOk && (cmd_op_e'(cmdOp) == OP_DISABLE);
    strb.enWr   = cmdValid && cmdOk && (cmd_op_e'(cmdOp) == OP_ENABLE);
    strb.rejHit = rejValid && inRange(rejNum);
    strb.eoiHit = eoiValid && inRange(eoiNum);
    strb.resend = resendReq;
    strb.launch = slotFree && anyDue;
  end

  assign cmdIdx    = toIdx(cmdNum);
  assign rejIdx    = toIdx(rejNum);
  assign eoiIdx    = toIdx(eoiNum);
  assign launchIdx = pickIdx;
  assign wrServer  = SRV_W'(cmdServer);
  assign wrPrio    = cmdPrio[7:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmdAck <= 1'b0;
      cmdErr <= 1'b0;
    end else begin
      cmdAck <= cmdValid;
      cmdErr <= cmdValid && !cmdOk;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      offerValid  <= 1'b0;
      offerNum    <= '0;
      offerServer <= '0;
      offerPrio   <= '0;
    end else if (strb.launch) begin
      offerValid  <= 1'b1;
      offerNum    <= NUM_W'(SRC_BASE) + NUM_W'(pickIdx);
      offerServer <= selServer;
      offerPrio   <= selPrio;
    end else if (offerReady) begin
      offerValid  <= 1'b0;
    end
  end

endmodule

// File: rtl/irq_source_ctrl_dp.sv
module irq_source_ctrl_dp
  import irq_source_ctrl_pkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int NUM_SERVERS = 4,
  localparam int IDX_W      = $clog2(NUM_SRC),
  localparam int SRV_W      = $clog2(NUM_SERVERS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] srcIsLevel,
  input  logic [NUM_SRC-1:0] srcLine,
  input  strobe_t            strb,
  input  logic [IDX_W-1:0]   cmdIdx,
  input  logic [IDX_W-1:0]   rejIdx,
  input  logic [IDX_W-1:0]   eoiIdx,
  input  logic [IDX_W-1:0]   launchIdx,
  input  logic [SRV_W-1:0]   wrServer,
  input  logic [7:0]         wrPrio,
  output logic [NUM_SRC-1:0] dueVec,
  output logic [SRV_W-1:0]   selServer,
  output logic [7:0]         selPrio
);

  function automatic logic canOffer(input logic [7:0] p, input logic a, input logic s);
    return (p != MASK_PRIO) && a && !s;
  endfunction

  logic [7:0]       prioArr [NUM_SRC];
  logic [SRV_W-1:0] srvArr  [NUM_SRC];

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic [7:0]       prioQ, savedQ, nPrio, nSaved;
    logic [SRV_W-1:0] srvQ, nSrv;
    logic asrtQ, sentQ, rejQ, mpQ, dueQ, lineQ;
    logic nAsrt, nSent, nRej, nMp, nDue;
    logic cmdHit;

    assign cmdHit = (strb.cfgWr || strb.disWr || strb.enWr) && (cmdIdx == IDX_W'(i));

    always_comb begin
      nPrio  = prioQ;
      nSaved = savedQ;
      nSrv   = srvQ;
      nAsrt  = asrtQ;
      nSent  = sentQ;
      nRej   = rejQ;
      nMp    = mpQ;
      nDue   = dueQ && !(strb.launch && (launchIdx == IDX_W'(i)));
      // input activity
      if (srcIsLevel[i]) begin
        if (srcLine[i] != nAsrt) begin
          nAsrt = srcLine[i];
          if (canOffer(nPrio, nAsrt, nSent)) begin
            nSent = 1'b1;
            nDue  = 1'b1;
          end
        end
      end else if (srcLine[i] && !lineQ) begin
        if (nPrio == MASK_PRIO) nMp  = 1'b1;
        else                    nDue = 1'b1;
      end
      // configuration commands
      if (cmdHit) begin
        if (strb.cfgWr) begin
          nSrv   = wrServer;
          nPrio  = wrPrio;
          nSaved = wrPrio;
        end else if (strb.disWr) begin
          nSaved = nPrio;
          nPrio  = MASK_PRIO;
        end else begin
          nPrio  = nSaved;
        end
        if (srcIsLevel[i]) begin
          if (canOffer(nPrio, nAsrt, nSent)) begin
            nSent = 1'b1;
            nDue  = 1'b1;
          end
        end else if (nMp && (nPrio != MASK_PRIO)) begin
          nMp  = 1'b0;
          nDue = 1'b1;
        end
      end
      // presentation-side notices
      if (strb.rejHit && (rejIdx == IDX_W'(i))) begin
        nRej  = 1'b1;
        nSent = 1'b0;
      end
      if (strb.eoiHit && (eoiIdx == IDX_W'(i)) && srcIsLevel[i]) begin
        nSent = 1'b0;
      end
      if (strb.resend) begin
        if (srcIsLevel[i]) begin
          if (canOffer(nPrio, nAsrt, nSent)) begin
            nSent = 1'b1;
            nDue  = 1'b1;
          end
        end else if (nRej) begin
          nRej = 1'b0;
          if (nPrio != MASK_PRIO) nDue = 1'b1;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prioQ  <= MASK_PRIO;
        savedQ <= MASK_PRIO;
        srvQ   <= '0;
        asrtQ  <= 1'b0;
        sentQ  <= 1'b0;
        rejQ   <= 1'b0;
        mpQ    <= 1'b0;
        dueQ   <= 1'b0;
        lineQ  <= 1'b0;
      end else begin
        prioQ  <= nPrio;
        savedQ <= nSaved;
        srvQ   <= nSrv;
        asrtQ  <= nAsrt;
        sentQ  <= nSent;
        rejQ   <= nRej;
        mpQ    <= nMp;
        dueQ   <= nDue;
        lineQ  <= srcLine[i];
      end
    end

    assign dueVec[i]  = dueQ;
    assign prioArr[i] = prioQ;
    assign srvArr[i]  = srvQ;
  end

  assign selPrio   = prioArr[launchIdx];
  assign selServer = srvArr[launchIdx];

endmodule

// File: rtl/irq_source_ctrl.sv
module irq_source_ctrl
  import irq_source_ctrl_pkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int SRC_BASE    = 16,
  parameter int NUM_SERVERS = 4,
  parameter int NUM_W       = 8,
  parameter int SRV_IN_W    = 8,
  localparam int IDX_W      = $clog2(NUM_SRC),
  localparam int SRV_W      = $clog2(NUM_SERVERS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SRC-1:0]  srcIsLevel,
  input  logic [NUM_SRC-1:0]  srcLine,
  input  logic                cmdValid,
  input  logic [1:0]          cmdOp,
  input  logic [NUM_W-1:0]    cmdNum,
  input  logic [SRV_IN_W-1:0] cmdServer,
  input  logic [8:0]          cmdPrio,
  output logic                cmdAck,
  output logic                cmdErr,
  input  logic                rejValid,
  input  logic [NUM_W-1:0]    rejNum,
  input  logic                eoiValid,
  input  logic [NUM_W-1:0]    eoiNum,
  input  logic                resendReq,
  output logic                offerValid,
  input  logic                offerReady,
  output logic [NUM_W-1:0]    offerNum,
  output logic [SRV_W-1:0]    offerServer,
  output logic [7:0]          offerPrio
);

  strobe_t          strb;
  logic [IDX_W-1:0] cmdIdx, rejIdx, eoiIdx, launchIdx;
  logic [SRV_W-1:0] wrServer, selServer;
  logic [7:0]       wrPrio, selPrio;
  logic [NUM_SRC-1:0] dueVec;

  irq_source_ctrl_ctl #(
    .NUM_SRC(NUM_SRC), .SRC_BASE(SRC_BASE), .NUM_SERVERS(NUM_SERVERS),
    .NUM_W(NUM_W), .SRV_IN_W(SRV_IN_W)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdNum(cmdNum),
    .cmdServer(cmdServer), .cmdPrio(cmdPrio),
    .rejValid(rejValid), .rejNum(rejNum),
    .eoiValid(eoiValid), .eoiNum(eoiNum), .resendReq(resendReq),
    .dueVec(dueVec), .selServer(selServer), .selPrio(selPrio),
    .offerReady(offerReady), .strb(strb),
    .cmdIdx(cmdIdx), .rejIdx(rejIdx), .eoiIdx(eoiIdx), .launchIdx(launchIdx),
    .wrServer(wrServer), .wrPrio(wrPrio),
    .cmdAck(cmdAck), .cmdErr(cmdErr),
    .offerValid(offerValid), .offerNum(offerNum),
    .offerServer(offerServer), .offerPrio(offerPrio)
  );

  irq_source_ctrl_dp #(
    .NUM_SRC(NUM_SRC), .NUM_SERVERS(NUM_SERVERS)
  ) u_dp (
    .clk(clk), .rst_n(rst_n),
    .srcIsLevel(srcIsLevel), .srcLine(srcLine), .strb(strb),
    .cmdIdx(cmdIdx), .rejIdx(rejIdx), .eoiIdx(eoiIdx), .launchIdx(launchIdx),
    .wrServer(wrServer), .wrPrio(wrPrio),
    .dueVec(dueVec), .selServer(selServer), .selPrio(selPrio)
  );

endmodule

// File: rtl/irq_source_ctrl_chk.sv
module irq_source_ctrl_chk #(
  parameter int NUM_SRC     = 8,
  parameter int SRC_BASE    = 16,
  parameter int NUM_SERVERS = 4,
  parameter int NUM_W       = 8,
  localparam int SRV_W      = $clog2(NUM_SERVERS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmdValid,
  input logic [NUM_W-1:0] cmdNum,
  input logic             cmdAck,
  input logic             cmdErr,
  input logic             offerValid,
  input logic             offerReady,
  input logic [NUM_W-1:0] offerNum,
  input logic [SRV_W-1:0] offerServer,
  input logic [7:0]       offerPrio
);

  AST_OFFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    offerValid && !offerReady |=> offerValid && $stable(offerNum)
      && $stable(offerServer) && $stable(offerPrio)); // R10

  AST_OFFER_NUM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    offerValid |-> (int'(offerNum) >= SRC_BASE)
      && (int'(offerNum) < SRC_BASE + NUM_SRC)); // R2

  AST_ACK_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    cmdValid |=> cmdAck); // R9

  AST_ACK_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    cmdAck |-> $past(cmdValid)); // R9

  AST_BAD_NUM_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    cmdValid && ((int'(cmdNum) < SRC_BASE) || (int'(cmdNum) >= SRC_BASE + NUM_SRC))
      |=> cmdErr); // R9

endmodule

bind irq_source_ctrl irq_source_ctrl_chk #(
  .NUM_SRC(NUM_SRC), .SRC_BASE(SRC_BASE), .NUM_SERVERS(NUM_SERVERS), .NUM_W(NUM_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdNum(cmdNum),
  .cmdAck(cmdAck), .cmdErr(cmdErr), .offerValid(offerValid),
  .offerReady(offerReady), .offerNum(offerNum),
  .offerServer(offerServer), .offerPrio(offerPrio)
);

// File: tb/tb_irq_source_ctrl.sv
`timescale 1ns/1ps
module tb_irq_source_ctrl;

  localparam int NS = 8;
  localparam int BASE = 16;
  localparam int NSRV = 4;
  localparam logic [NS-1:0] LVL = 8'hF0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NS-1:0] srcLine = '0;
  logic cmdValid = 1'b0;
  logic [1:0] cmdOp = '0;
  logic [7:0] cmdNum = '0, cmdServer = '0;
  logic [8:0] cmdPrio = '0;
  logic cmdAck, cmdErr;
  logic rejValid = 1'b0, eoiValid = 1'b0, resendReq = 1'b0;
  logic [7:0] rejNum = '0, eoiNum = '0;
  logic offerValid;
  logic offerReady = 1'b1;
  logic [7:0] offerNum;
  logic [1:0] offerServer;
  logic [7:0] offerPrio;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_source_ctrl #(.NUM_SRC(NS), .SRC_BASE(BASE), .NUM_SERVERS(NSRV)) dut (
    .clk(clk), .rst_n(rst_n), .srcIsLevel(LVL), .srcLine(srcLine),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdNum(cmdNum),
    .cmdServer(cmdServer), .cmdPrio(cmdPrio),
    .cmdAck(cmdAck), .cmdErr(cmdErr),
    .rejValid(rejValid), .rejNum(rejNum),
    .eoiValid(eoiValid), .eoiNum(eoiNum), .resendReq(resendReq),
    .offerValid(offerValid), .offerReady(offerReady), .offerNum(offerNum),
    .offerServer(offerServer), .offerPrio(offerPrio)
  );

  // ---------------- behavioural reference model ----------------
  int  mPr[NS], mSv[NS], mSrv[NS];
  bit  mAs[NS], mSe[NS], mRj[NS], mMp[NS], mDue[NS], mLn[NS];
  bit  mOV, mAck, mErr;
  int  mONum, mOSrv, mOPr, pick, hitIdx;
  bit  cmdGood;

  task automatic lvlTry(int i);
    if (mPr[i] != 255 && mAs[i] && !mSe[i]) begin mSe[i] = 1; mDue[i] = 1; end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NS; i++) begin
        mPr[i] = 255; mSv[i] = 255; mSrv[i] = 0;
        mAs[i] = 0; mSe[i] = 0; mRj[i] = 0; mMp[i] = 0; mDue[i] = 0; mLn[i] = 0;
      end
      mOV = 0; mAck = 0; mErr = 0; mONum = 0; mOSrv = 0; mOPr = 0;
    end else begin
      pick = -1;
      for (int i = NS - 1; i >= 0; i--) if (mDue[i]) pick = i;
      if (!mOV || offerReady) begin
        if (pick >= 0) begin
          mOV = 1; mONum = BASE + pick; mOSrv = mSrv[pick]; mOPr = mPr[pick];
          mDue[pick] = 0;
        end else mOV = 0;
      end
      hitIdx = int'(cmdNum) - BASE;
      cmdGood = (hitIdx >= 0) && (hitIdx < NS);
      if (cmdOp == 2'd0) cmdGood = cmdGood && (int'(cmdServer) < NSRV) && (cmdPrio <= 9'd255);
      if (cmdOp == 2'd3) cmdGood = 0;
      mAck = cmdValid;
      mErr = cmdValid && !cmdGood;
      for (int i = 0; i < NS; i++) begin
        if (LVL[i]) begin
          if (srcLine[i] != mAs[i]) begin mAs[i] = srcLine[i]; lvlTry(i); end
        end else if (srcLine[i] && !mLn[i]) begin
          if (mPr[i] == 255) mMp[i] = 1; else mDue[i] = 1;
        end
        mLn[i] = srcLine[i];
        if (cmdValid && cmdGood && hitIdx == i) begin
          if (cmdOp == 2'd0) begin mSrv[i] = int'(cmdServer); mPr[i] = int'(cmdPrio); mSv[i] = int'(cmdPrio); end
          else if (cmdOp == 2'd1) begin mSv[i] = mPr[i]; mPr[i] = 255; end
          else mPr[i] = mSv[i];
          if (LVL[i]) lvlTry(i);
          else if (mMp[i] && mPr[i] != 255) begin mMp[i] = 0; mDue[i] = 1; end
        end
        if (rejValid && int'(rejNum) - BASE == i) begin mRj[i] = 1; mSe[i] = 0; end
        if (eoiValid && int'(eoiNum) - BASE == i && LVL[i]) mSe[i] = 0;
        if (resendReq) begin
          if (LVL[i]) lvlTry(i);
          else if (mRj[i]) begin mRj[i] = 0; if (mPr[i] != 255) mDue[i] = 1; end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (offerValid !== mOV || (mOV && (int'(offerNum) != mONum ||
          int'(offerServer) != mOSrv || int'(offerPrio) != mOPr))) begin
        errors++;
        $display("FAIL R10 model offer: got v%0b n%0d s%0d p%0d exp v%0b n%0d s%0d p%0d",
                 offerValid, offerNum, offerServer, offerPrio, mOV, mONum, mOSrv, mOPr);
      end
      checks++;
      if (cmdAck !== mAck || (mAck && cmdErr !== mErr)) begin
        errors++;
        $display("FAIL R9 model ack: got a%0b e%0b exp a%0b e%0b", cmdAck, cmdErr, mAck, mErr);
      end
    end
  end

  // ---------------- directed stimulus helpers ----------------
  task automatic check(bit ok, string tag, int got, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d exp %0d", tag, got, exp);
    end
  endtask

  task automatic doCmd(int op, int num, int srv, int pr, bit expErr, string tag);
    @(negedge clk);
    cmdValid = 1; cmdOp = 2'(op); cmdNum = 8'(num); cmdServer = 8'(srv); cmdPrio = 9'(pr);
    @(negedge clk);
    cmdValid = 0;
    check(cmdAck === 1'b1 && cmdErr === expErr, tag, int'(cmdErr), int'(expErr));
  endtask

  task automatic pulseLine(int i);
    @(negedge clk); srcLine[i] = 1;
    @(negedge clk); srcLine[i] = 0;
  endtask

  task automatic setLine(int i, bit v);
    @(negedge clk); srcLine[i] = v;
  endtask

  task automatic doReject(int num);
    @(negedge clk); rejValid = 1; rejNum = 8'(num);
    @(negedge clk); rejValid = 0;
  endtask

  task automatic doEoi(int num);
    @(negedge clk); eoiValid = 1; eoiNum = 8'(num);
    @(negedge clk); eoiValid = 0;
  endtask

  task automatic doResend();
    @(negedge clk); resendReq = 1;
    @(negedge clk); resendReq = 0;
  endtask

  task automatic expectOffer(int num, int srv, int pr, string tag);
    bit found = 0;
    for (int k = 0; k < 12 && !found; k++) begin
      @(negedge clk);
      if (offerValid && offerReady) begin
        found = 1;
        check(int'(offerNum) == num, {tag, " num"}, int'(offerNum), num);
        check(int'(offerServer) == srv, {tag, " server"}, int'(offerServer), srv);
        check(int'(offerPrio) == pr, {tag, " prio"}, int'(offerPrio), pr);
      end
    end
    if (!found) check(0, {tag, " no offer"}, 0, 1);
  endtask

  task automatic expectQuiet(int n, string tag);
    bit seen = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (offerValid) seen = 1;
    end
    check(!seen, tag, int'(seen), 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(offerValid === 1'b0 && cmdAck === 1'b0, "R1 reset outputs", int'(offerValid), 0);
    // masked message edge is remembered, not offered
    pulseLine(0);
    expectQuiet(5, "R1 masked after reset");
    doCmd(0, 16, 2, 5, 0, "R7 configure ack");
    expectOffer(16, 2, 5, "R7 masked-pending release");
    pulseLine(0);
    expectOffer(16, 2, 5, "R2 message edge offer");
    // level source
    doCmd(0, 20, 1, 3, 0, "R7 level configure ack");
    expectQuiet(4, "R3 level idle no offer");
    setLine(4, 1);
    expectOffer(20, 1, 3, "R3 level assert offer");
    expectQuiet(6, "R3 level held no repeat");
    doReject(20);
    expectQuiet(6, "R4 reject no offer");
    doResend();
    expectOffer(20, 1, 3, "R6 level resend");
    doEoi(20);
    expectQuiet(5, "R5 eoi alone no offer");
    doResend();
    expectOffer(20, 1, 3, "R5 level eoi then resend");
    setLine(4, 0);
    doEoi(20);
    doResend();
    expectQuiet(5, "R6 deasserted level resend");
    // message reject and resend
    doReject(16);
    doResend();
    expectOffer(16, 2, 5, "R6 message re-offer");
    doResend();
    expectQuiet(5, "R6 message single re-offer");
    doEoi(16);
    doResend();
    expectQuiet(5, "R5 eoi on message no effect");
    // disable / enable
    doCmd(1, 16, 0, 0, 0, "R8 disable ack");
    pulseLine(0);
    expectQuiet(5, "R8 disabled no offer");
    doCmd(2, 16, 0, 0, 0, "R8 enable ack");
    expectOffer(16, 2, 5, "R8 enable restores priority");
    // refused commands
    doCmd(0, 15, 1, 1, 1, "R9 number below base");
    doCmd(0, 24, 1, 1, 1, "R9 number above range");
    doCmd(0, 16, 4, 1, 1, "R9 server out of range");
    doCmd(0, 16, 1, 256, 1, "R9 priority above 0xFF");
    doCmd(1, 24, 0, 0, 1, "R9 disable bad number");
    doCmd(3, 16, 0, 0, 1, "R9 invalid opcode");
    pulseLine(0);
    expectOffer(16, 2, 5, "R9 state unchanged");
    doCmd(0, 16, 3, 4, 0, "R7 reconfigure ack");
    pulseLine(0);
    expectOffer(16, 3, 4, "R7 new server and prio");
    // ordering and stall
    doCmd(0, 17, 0, 7, 0, "R10 config 17");
    doCmd(0, 18, 3, 1, 0, "R10 config 18");
    @(negedge clk);
    offerReady = 0;
    srcLine[0] = 1; srcLine[1] = 1; srcLine[2] = 1;
    @(negedge clk);
    srcLine[0] = 0; srcLine[1] = 0; srcLine[2] = 0;
    @(negedge clk);
    check(offerValid && int'(offerNum) == 16, "R10 lowest first", int'(offerNum), 16);
    repeat (3) @(negedge clk);
    check(offerValid && int'(offerNum) == 16 && int'(offerPrio) == 4,
          "R10 held while not ready", int'(offerNum), 16);
    offerReady = 1;
    expectOffer(17, 0, 7, "R10 second in order");
    expectOffer(18, 3, 1, "R10 third in order");
    expectQuiet(4, "R10 burst drained");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule